// File: doc/BRIEF.md
# DMA Channel Control Sequencer

This block is the per-channel control logic of a DMA engine. It holds one memory-mapped control word with four fields: channel enable, linked-list enable, a software force trigger and a keep-running-in-standby bit. It walks the channel through five phases: idle, armed and waiting for a trigger, block active, block suspended, and next-descriptor fetch. The data mover and the descriptor memory reads stay outside the block. The data mover is reached through a start strobe, a run qualifier and done/abort pulses. The descriptor memory is reached through a request/acknowledge pair that carries the next-descriptor pointer.

Software arms a channel by setting enable. A selected hardware trigger or a software force then starts one block. Hardware drops enable when the block finishes or aborts. If software drops enable during a block, the block is suspended, and writing enable back resumes it. With linked-list mode on, the channel fetches the next descriptor after a finished block, or at once while it is idle and disarmed. An all-ones pointer stops the chain instead: the channel raises a sticky flag and turns linked-list mode off.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the control word reads 0 and blk_start, mover_go, blk_busy, suspended, waiting, desc_req and ll_flag are all 0.
- R2: A write lands only when reg_addr equals 0x50 + CHAN*0x50. The fields are enable at bit 0, linked-list enable at bit 8, force trigger at bit 16 and run-in-standby at bit 24. Bit 16 always reads 0, and a write to any other address changes nothing.
- R3: While enable is 1 (including a write that sets it in the same cycle) and the channel is idle and not halted, a hw_trig pulse or a written force bit makes blk_start high for exactly one cycle, in the cycle after the trigger. blk_busy rises in that same cycle.
- R4: A trigger is ignored and not remembered when enable is 0, or when the channel is halted (standby=1 with run-in-standby=0).
- R5: blk_done or blk_abort while a block is active clears enable and ends the block. This hardware clear wins over a software write in the same cycle.
- R6: Writing enable=0 while a block is active makes suspended=1 and mover_go=0. Writing enable=1 resumes the block with no new blk_start.
- R7: mover_go is 1 only while a block is active and not suspended, and is 0 while the channel is halted. Run-in-standby=1 keeps it running in standby.
- R8: With linked-list enable on, blk_done (without abort) on a non-null pointer raises desc_req, with desc_addr equal to next_ptr, in the next cycle. desc_req is held until desc_ack. The acknowledge then sets enable and leaves the channel waiting for a trigger.
- R9: If next_ptr is 0xFFFF_FFFF when a fetch would start, no fetch is requested, ll_flag is set and linked-list enable is cleared. ll_flag is cleared by a llf_clr pulse.
- R10: While idle with enable 0, not halted, and linked-list enable 1, the channel starts a descriptor fetch on its own in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control word |
| next_ptr | input | PTR_W | Next-descriptor pointer |
| hw_trig | input | 1 | Selected hardware start trigger |
| standby | input | 1 | System standby indication |
| blk_done | input | 1 | Block completed pulse from data mover |
| blk_abort | input | 1 | Block aborted pulse from data mover |
| desc_ack | input | 1 | Descriptor fetch finished |
| llf_clr | input | 1 | Clears the linked-list flag |
| blk_start | output | 1 | One-cycle start-of-block strobe |
| mover_go | output | 1 | Data mover may proceed |
| blk_busy | output | 1 | Block active or suspended |
| suspended | output | 1 | Block suspended |
| waiting | output | 1 | Armed, waiting for a trigger |
| desc_req | output | 1 | Descriptor fetch request |
| desc_addr | output | PTR_W | Address of the descriptor to fetch |
| ll_flag | output | 1 | Null pointer reached in linked-list mode |

## Verification
Every registered result appears one cycle after the stimulus edge: blk_start, the busy and suspended status, desc_req, ll_flag and the control word. mover_go is the exception: it also follows standby in the same cycle. An idle-mode fetch shows one cycle after the write that enables linked-list mode takes effect. The bench drives inputs at the falling edge and samples a quarter period before the next rising edge. There it compares every output against a behavioural reference model that the rising edge advanced. Directed checks at the same sampling point confirm each corner case.

// File: rtl/dcc_pkg.sv
// Shared types and field positions of the DMA channel control sequencer.
package dcc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_SUSP  = 2'd2,
        ST_FETCH = 2'd3
    } dcc_state_e;

    localparam int EN_BIT  = 0;
    localparam int LL_BIT  = 8;
    localparam int SWF_BIT = 16;
    localparam int RSB_BIT = 24;
    localparam int WORD_W  = 32;
endpackage

// File: rtl/dcc_regs.sv
// Control word and linked-list flag of one channel.
// Assumes hardware set/clear requests come from dcc_seq. Hardware requests
// take priority over a software write in the same cycle. The force bit is
// a pulse and is never stored.
module dcc_regs
    import dcc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CHAN   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              hw_en_clr,
    input  logic              hw_en_set,
    input  logic              hw_ll_clr,
    input  logic              llf_set,
    input  logic              llf_clr,
    output logic              en_q,
    output logic              ll_q,
    output logic              rsb_q,
    output logic              llf_q,
    output logic              wr_hit,
    output logic              sw_force,
    output logic [WORD_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(32'h50 + 32'(CHAN) * 32'h50);

    // Address decode of a write and extraction of the force pulse.
    always_comb begin
        wr_hit   = wr_en && (wr_addr == BASE_ADDR);
        sw_force = wr_hit && wr_data[SWF_BIT];
    end

    // Field update: software write first, hardware overrides.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            ll_q  <= 1'b0;
            rsb_q <= 1'b0;
            llf_q <= 1'b0;
        end else begin
            if (hw_en_clr)      en_q <= 1'b0;
            else if (hw_en_set) en_q <= 1'b1;
            else if (wr_hit)    en_q <= wr_data[EN_BIT];
            if (hw_ll_clr)      ll_q <= 1'b0;
            else if (wr_hit)    ll_q <= wr_data[LL_BIT];
            if (wr_hit)         rsb_q <= wr_data[RSB_BIT];
            if (llf_set)        llf_q <= 1'b1;
            else if (llf_clr)   llf_q <= 1'b0;
        end
    end

    // Read-back image; the force bit reads as zero.
    always_comb begin
        rd_data          = '0;
        rd_data[EN_BIT]  = en_q;
        rd_data[LL_BIT]  = ll_q;
        rd_data[RSB_BIT] = rsb_q;
    end
endmodule

// File: rtl/dcc_seq.sv
// Phase sequencer of one channel: idle/armed, active, suspended, fetch.
// Assumes done/abort are single-cycle pulses and next_ptr is stable while
// a fetch decision is made. Armed means idle with enable set.
module dcc_seq
    import dcc_pkg::*;
#(
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_eff,
    input  logic             ll_q,
    input  logic             halted,
    input  logic             hw_trig,
    input  logic             sw_force,
    input  logic             wr_hit,
    input  logic             wr_en_val,
    input  logic             blk_done,
    input  logic             blk_abort,
    input  logic             desc_ack,
    input  logic [PTR_W-1:0] next_ptr,
    output dcc_state_e       state,
    output logic             blk_start,
    output logic [PTR_W-1:0] desc_addr,
    output logic             hw_en_clr,
    output logic             hw_en_set,
    output logic             hw_ll_clr,
    output logic             llf_set
);
    dcc_state_e state_nxt;
    logic       start_now;
    logic       link_try;
    logic       ptr_null;

    // Event decode for the current cycle.
    always_comb begin
        ptr_null  = &next_ptr;
        start_now = (state == ST_IDLE) && en_eff && !halted && (hw_trig || sw_force);
        link_try  = ll_q && (((state == ST_BUSY) && blk_done && !blk_abort) ||
                             ((state == ST_IDLE) && !en_eff && !halted));
        hw_en_clr = ((state == ST_BUSY) && (blk_done || blk_abort)) ||
                    ((state == ST_SUSP) && blk_abort);
        hw_en_set = (state == ST_FETCH) && desc_ack;
        llf_set   = link_try && ptr_null;
        hw_ll_clr = llf_set;
    end

    // Next-phase selection.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start_now)                  state_nxt = ST_BUSY;
                else if (link_try && !ptr_null) state_nxt = ST_FETCH;
            end
            ST_BUSY: begin
                if (blk_done || blk_abort)
                    state_nxt = (link_try && !ptr_null) ? ST_FETCH : ST_IDLE;
                else if (wr_hit && !wr_en_val)
                    state_nxt = ST_SUSP;
            end
            ST_SUSP: begin
                if (blk_abort)                  state_nxt = ST_IDLE;
                else if (wr_hit && wr_en_val)   state_nxt = ST_BUSY;
            end
            ST_FETCH: begin
                if (desc_ack)                   state_nxt = ST_IDLE;
            end
            default:                            state_nxt = ST_IDLE;
        endcase
    end

    // Phase, start strobe and latched descriptor address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            blk_start <= 1'b0;
            desc_addr <= '0;
        end else begin
            state     <= state_nxt;
            blk_start <= start_now;
            if (link_try && !ptr_null) desc_addr <= next_ptr;
        end
    end
endmodule

// File: rtl/dma_chan_ctrl.sv
// Top of the DMA channel control sequencer: joins the control word to the
// phase sequencer and derives the status outputs.
// Assumes one channel per instance, selected by CHAN (0..15).
module dma_chan_ctrl
    import dcc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int PTR_W  = 32,
    parameter int CHAN   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [PTR_W-1:0]  next_ptr,
    input  logic              hw_trig,
    input  logic              standby,
    input  logic              blk_done,
    input  logic              blk_abort,
    input  logic              desc_ack,
    input  logic              llf_clr,
    output logic              blk_start,
    output logic              mover_go,
    output logic              blk_busy,
    output logic              suspended,
    output logic              waiting,
    output logic              desc_req,
    output logic [PTR_W-1:0]  desc_addr,
    output logic              ll_flag
);
    logic       en_q, ll_q, rsb_q, wr_hit, sw_force;
    logic       hw_en_clr, hw_en_set, hw_ll_clr, llf_set;
    logic       en_eff, halted;
    dcc_state_e state;

    dcc_regs #(.ADDR_W(ADDR_W), .CHAN(CHAN)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
        .wr_data(reg_wdata), .hw_en_clr(hw_en_clr), .hw_en_set(hw_en_set),
        .hw_ll_clr(hw_ll_clr), .llf_set(llf_set), .llf_clr(llf_clr),
        .en_q(en_q), .ll_q(ll_q), .rsb_q(rsb_q), .llf_q(ll_flag),
        .wr_hit(wr_hit), .sw_force(sw_force), .rd_data(reg_rdata)
    );

    // Enable as seen this cycle, and the standby halt condition.
    always_comb begin
        en_eff = wr_hit ? reg_wdata[EN_BIT] : en_q;
        halted = standby && !rsb_q;
    end

    dcc_seq #(.PTR_W(PTR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .en_eff(en_eff), .ll_q(ll_q),
        .halted(halted), .hw_trig(hw_trig), .sw_force(sw_force),
        .wr_hit(wr_hit), .wr_en_val(reg_wdata[EN_BIT]),
        .blk_done(blk_done), .blk_abort(blk_abort), .desc_ack(desc_ack),
        .next_ptr(next_ptr), .state(state), .blk_start(blk_start),
        .desc_addr(desc_addr), .hw_en_clr(hw_en_clr), .hw_en_set(hw_en_set),
        .hw_ll_clr(hw_ll_clr), .llf_set(llf_set)
    );

    // Status outputs derived from the phase.
    always_comb begin
        blk_busy  = (state == ST_BUSY) || (state == ST_SUSP);
        suspended = (state == ST_SUSP);
        mover_go  = (state == ST_BUSY) && !halted;
        waiting   = (state == ST_IDLE) && en_q;
        desc_req  = (state == ST_FETCH);
    end
endmodule

// File: rtl/dcc_chk.sv
// Port-level properties of dma_chan_ctrl, attached by bind.
module dcc_chk #(
    parameter int PTR_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      reg_rdata,
    input logic             standby,
    input logic             blk_done,
    input logic             blk_abort,
    input logic             desc_ack,
    input logic             blk_start,
    input logic             mover_go,
    input logic             blk_busy,
    input logic             suspended,
    input logic             desc_req,
    input logic [PTR_W-1:0] desc_addr
);
    // R2
    force_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[16] == 1'b0);
    // R3
    start_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start |-> blk_busy && !suspended);
    // R3
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start |=> !blk_start);
    // R5
    end_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_busy && !suspended && (blk_done || blk_abort)) |=> !reg_rdata[0] && !blk_busy);
    // R6
    resume_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(suspended) && blk_busy) |-> !blk_start);
    // R7
    halt_stops_mover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && !reg_rdata[24]) |-> !mover_go);
    // R8
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_req && !desc_ack) |=> desc_req && $stable(desc_addr));
    // R9
    no_null_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_req |-> !(&desc_addr));
endmodule

bind dma_chan_ctrl dcc_chk #(.PTR_W(PTR_W)) u_dcc_chk (
    .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .standby(standby),
    .blk_done(blk_done), .blk_abort(blk_abort), .desc_ack(desc_ack),
    .blk_start(blk_start), .mover_go(mover_go), .blk_busy(blk_busy),
    .suspended(suspended), .desc_req(desc_req), .desc_addr(desc_addr)
);

// File: tb/tb_dma_chan_ctrl.sv
`timescale 1ns/1ps
module tb_dma_chan_ctrl;
    localparam logic [11:0] BASE = 12'h050;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] next_ptr = '0;
    logic        hw_trig = 1'b0, standby = 1'b0, blk_done = 1'b0, blk_abort = 1'b0;
    logic        desc_ack = 1'b0, llf_clr = 1'b0;
    logic        blk_start, mover_go, blk_busy, suspended, waiting, desc_req, ll_flag;
    logic [31:0] desc_addr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dma_chan_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .next_ptr(next_ptr),
        .hw_trig(hw_trig), .standby(standby), .blk_done(blk_done),
        .blk_abort(blk_abort), .desc_ack(desc_ack), .llf_clr(llf_clr),
        .blk_start(blk_start), .mover_go(mover_go), .blk_busy(blk_busy),
        .suspended(suspended), .waiting(waiting), .desc_req(desc_req),
        .desc_addr(desc_addr), .ll_flag(ll_flag)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: phase 0 idle, 1 active, 2 suspended, 3 fetch.
    int          m_ph = 0;
    bit          m_en = 0, m_ll = 0, m_rsb = 0, m_llf = 0, m_start = 0;
    logic [31:0] m_ptr = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_en = 0; m_ll = 0; m_rsb = 0; m_llf = 0; m_start = 0; m_ptr = '0;
        end else begin
            bit hit, want_en, halt, go_link, clr, setb, isnull;
            int nx;
            hit = reg_wr && (reg_addr == BASE);
            want_en = hit ? reg_wdata[0] : m_en;
            halt = standby && !m_rsb;
            isnull = (next_ptr == 32'hFFFF_FFFF);
            nx = m_ph; go_link = 0; clr = 0; setb = 0; m_start = 0;
            if (m_ph == 0) begin
                if (want_en && !halt && (hw_trig || (hit && reg_wdata[16]))) begin
                    nx = 1; m_start = 1;
                end else if (!want_en && m_ll && !halt) go_link = 1;
            end else if (m_ph == 1) begin
                if (blk_done || blk_abort) begin
                    clr = 1; nx = 0;
                    go_link = blk_done && !blk_abort && m_ll;
                end else if (hit && !reg_wdata[0]) nx = 2;
            end else if (m_ph == 2) begin
                if (blk_abort) begin clr = 1; nx = 0; end
                else if (hit && reg_wdata[0]) nx = 1;
            end else if (desc_ack) begin
                setb = 1; nx = 0;
            end
            if (hit) begin m_en = reg_wdata[0]; m_rsb = reg_wdata[24]; end
            if (clr) m_en = 0;
            if (setb) m_en = 1;
            if (go_link && isnull) begin
                m_ll = 0; m_llf = 1;
            end else begin
                if (hit) m_ll = reg_wdata[8];
                if (llf_clr) m_llf = 0;
                if (go_link) begin nx = 3; m_ptr = next_ptr; end
            end
            m_ph = nx;
        end
    end

    // Cycle-by-cycle comparison, a quarter period before the rising edge.
    always @(negedge clk) begin
        #5;
        if (rst_n) begin
            logic [31:0] img;
            img = {7'd0, m_rsb, 15'd0, m_ll, 7'd0, m_en};
            chk(reg_rdata == img, "R2 control word", reg_rdata, img);
            chk(blk_start == m_start, "R3 blk_start", 32'(blk_start), 32'(m_start));
            chk(blk_busy == (m_ph == 1 || m_ph == 2), "R5 blk_busy", 32'(blk_busy), 32'(m_ph == 1 || m_ph == 2));
            chk(suspended == (m_ph == 2), "R6 suspended", 32'(suspended), 32'(m_ph == 2));
            chk(mover_go == (m_ph == 1 && !(standby && !m_rsb)), "R7 mover_go", 32'(mover_go), 32'(m_ph == 1 && !(standby && !m_rsb)));
            chk(waiting == (m_ph == 0 && m_en), "R8 waiting", 32'(waiting), 32'(m_ph == 0 && m_en));
            chk(desc_req == (m_ph == 3), "R8 desc_req", 32'(desc_req), 32'(m_ph == 3));
            if (m_ph == 3) chk(desc_addr == m_ptr, "R8 desc_addr", desc_addr, m_ptr);
            chk(ll_flag == m_llf, "R9 ll_flag", 32'(ll_flag), 32'(m_llf));
        end
    end

    task automatic wr_at(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: hw_trig = 1'b1;
            1: blk_done = 1'b1;
            2: blk_abort = 1'b1;
            3: desc_ack = 1'b1;
            default: llf_clr = 1'b1;
        endcase
        @(negedge clk);
        hw_trig = 1'b0; blk_done = 1'b0; blk_abort = 1'b0; desc_ack = 1'b0; llf_clr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;
        // R1 reset state
        chk(reg_rdata == 0, "R1 rdata", reg_rdata, 0);
        chk({blk_start, mover_go, blk_busy, suspended, waiting, desc_req, ll_flag} == 0,
            "R1 outputs", 32'({blk_start, mover_go, blk_busy, suspended, waiting, desc_req, ll_flag}), 0);

        // R2 write to another channel's address is ignored
        wr_at(12'h0A0, 32'h0100_0101); #5;
        chk(reg_rdata == 0, "R2 wrong address", reg_rdata, 0);

        // R2/R3 enable + force + run-in-standby in one write
        wr_at(BASE, 32'h0101_0001); #5;
        chk(reg_rdata == 32'h0100_0001, "R2 readback", reg_rdata, 32'h0100_0001);
        chk(blk_start && blk_busy, "R3 force start", 32'({blk_start, blk_busy}), 32'h3);

        // R5 done clears enable
        pulse(1); #5;
        chk(!blk_busy && reg_rdata[0] == 0, "R5 done clear", reg_rdata, 32'h0100_0000);

        // R4 trigger with enable 0 ignored
        pulse(0); #5;
        chk(!blk_busy, "R4 disabled trigger", 32'(blk_busy), 0);

        // R4 halted trigger ignored and not queued
        wr_at(BASE, 32'h1);
        standby = 1'b1;
        pulse(0); #5;
        chk(!blk_busy, "R4 halted trigger", 32'(blk_busy), 0);
        @(negedge clk); standby = 1'b0;
        @(negedge clk); #5;
        chk(!blk_busy && waiting, "R4 not queued", 32'({blk_busy, waiting}), 32'h1);

        // R3 hardware trigger
        pulse(0); #5;
        chk(blk_start && mover_go, "R3 hw start", 32'({blk_start, mover_go}), 32'h3);

        // R7 standby halts the mover
        @(negedge clk); standby = 1'b1; #5;
        chk(!mover_go && blk_busy, "R7 halted", 32'({mover_go, blk_busy}), 32'h1);
        @(negedge clk); standby = 1'b0; #5;
        chk(mover_go, "R7 resumed", 32'(mover_go), 1);

        // R6 suspend and resume
        wr_at(BASE, 32'h0); #5;
        chk(suspended && !mover_go, "R6 suspend", 32'({suspended, mover_go}), 32'h2);
        wr_at(BASE, 32'h1); #5;
        chk(!suspended && blk_busy && !blk_start, "R6 resume", 32'({suspended, blk_busy, blk_start}), 32'h2);

        // R5 hardware clear beats a same-cycle write
        @(negedge clk); blk_done = 1'b1; reg_wr = 1'b1; reg_addr = BASE; reg_wdata = 32'h1;
        @(negedge clk); blk_done = 1'b0; reg_wr = 1'b0; reg_wdata = '0; #5;
        chk(reg_rdata == 0 && !blk_busy, "R5 priority", reg_rdata, 0);

        // R8 linked fetch after done
        next_ptr = 32'h1000_0040;
        wr_at(BASE, 32'h101);
        pulse(0);
        pulse(1); #5;
        chk(desc_req && desc_addr == 32'h1000_0040, "R8 fetch", desc_addr, 32'h1000_0040);
        pulse(3); #5;
        chk(!desc_req && waiting && reg_rdata == 32'h101, "R8 ack", reg_rdata, 32'h101);

        // R9 null pointer stops the chain
        next_ptr = 32'hFFFF_FFFF;
        pulse(0);
        pulse(1); #5;
        chk(ll_flag && !desc_req && reg_rdata == 0, "R9 null", reg_rdata, 0);
        pulse(4); #5;
        chk(!ll_flag, "R9 flag clear", 32'(ll_flag), 0);

        // R10 idle fetch with enable 0
        next_ptr = 32'h2000_0000;
        wr_at(BASE, 32'h100);
        @(negedge clk); #5;
        chk(desc_req && desc_addr == 32'h2000_0000, "R10 idle fetch", desc_addr, 32'h2000_0000);
        pulse(3); #5;
        chk(reg_rdata == 32'h101, "R10 ack", reg_rdata, 32'h101);

        // R5 abort ends the block
        pulse(0);
        pulse(2); #5;
        chk(!blk_busy && reg_rdata[0] == 0, "R5 abort", reg_rdata, 32'h100);
        @(negedge clk); #5;
        pulse(3);
        repeat (3) @(negedge clk);
        #5;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule